// File: doc/BRIEF.md
# Companion-Chip Register and GPIO Block

This block is the register file of a small companion chip. The host reaches it over a plain single-cycle bus: an address, separate read and write strobes, write data and registered read data. The bus decodes a 4 KiB window. The window holds eight control words:

- an operating-mode word
- a divider word
- a fixed status word
- a power word
- a clock-control word
- three interrupt words, which are plain storage with no interrupt logic behind them

The window also holds a 16-line GPIO unit. A direction word picks which lines are outputs. A level word holds the output values, and it is always masked by the direction in force when it is written. The driven pins carry level AND direction. Whenever a write to the direction or level word makes a driven pin toggle, a change strobe pulses for one clock on exactly that line. The same unit samples the 16 input pins every clock. Its read-side offset returns a blend: the output level for lines configured as outputs, and the sampled pin for lines configured as inputs.

There is no sequencing state. Every access completes in one clock. The decoder maps each address to one register-select code, and the read mux acts on that code. An access whose address decodes to no register raises a one-clock error pulse.

Top module: `cgp_top`

## Requirements
- R1: Offsets 0x000 (mode), 0x004 (divider), 0x010 (clock control), 0x014, 0x018 and 0x01C (interrupt words) are read/write. Each write stores only bits 15:0 of the write data, and every read returns zero in bits 31:16.
- R2: After reset, the status word reads 0x0002 and every other register, gpio_out, gpio_chg and bus_err read zero.
- R3: The status word at 0x008 is read-only, so a write to it leaves the value read back at 0x0002.
- R4: A write to the power word at 0x00C stores the value. If bit 7 of the written value is 1, bits 15 and 6 are also set (0x0081 reads back as 0x80C1). Otherwise the value is stored unchanged.
- R5: A write to 0x024 or 0x028 stores the write data ANDed with the current direction word into the level word.
- R6: A read of 0x020 returns the direction word, and a read of 0x024 returns the level word.
- R7: A read of 0x028 returns, bit by bit, the level bit where the direction bit is 1 and the registered sample of gpio_in where it is 0. The input pins never alter the level word.
- R8: gpio_out equals the level word ANDed with the direction word. It takes its new value in the clock after the write.
- R9: After a write to the direction or level word, gpio_chg is high for exactly the one clock after the write, on exactly the bits where gpio_out toggled. It is zero when no driven bit toggled.
- R10: A read or write to any other offset, including a misaligned one, returns zero read data and changes no register. It raises bus_err for the one clock after the access.
- R11: bus_rdata is valid in the clock after bus_rd, and it holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte offset inside the window |
| bus_rd | input | 1 | Read request |
| bus_wr | input | 1 | Write request |
| bus_wdata | input | 32 | Write data; only bits 15:0 are kept |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | One-clock pulse after an undecoded access |
| gpio_in | input | 16 | Input pins, sampled every clock |
| gpio_out | output | 16 | Driven pin levels |
| gpio_chg | output | 16 | Per-line one-clock toggle strobe |

## Verification
The bench builds the block with its defaults: a 12-bit address, a 32-bit bus, 16-bit registers and 16 GPIO lines. With a 32-bit bus, a write can carry nonzero upper bits, so truncation to 16 bits is visible. With all 16 lines present, one pattern can mix output and input lines. That mix lets the bench reach these cases:
- direction changes that toggle some driven pins and leave others alone
- level bits that stay stored while their line is turned into an input
- a level rewrite that toggles nothing and so must give a zero strobe
- the read offset returning level bits and sampled pins side by side

// File: rtl/cgp_pkg.sv
package cgp_pkg;

    // Byte offsets inside the 4 KiB window
    localparam int OFS_MODE    = 'h000;
    localparam int OFS_DIV     = 'h004;
    localparam int OFS_STAT    = 'h008;
    localparam int OFS_PWR     = 'h00C;
    localparam int OFS_CLK     = 'h010;
    localparam int OFS_IRQ_REQ = 'h014;
    localparam int OFS_IRQ_MSK = 'h018;
    localparam int OFS_IRQ_STS = 'h01C;
    localparam int OFS_DIR     = 'h020;
    localparam int OFS_LVL_W   = 'h024;
    localparam int OFS_LVL_R   = 'h028;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_MODE,
        SEL_DIV,
        SEL_STAT,
        SEL_PWR,
        SEL_CLK,
        SEL_IRQ_REQ,
        SEL_IRQ_MSK,
        SEL_IRQ_STS,
        SEL_DIR,
        SEL_LVL_W,
        SEL_LVL_R
    } reg_sel_e;

endpackage

// File: rtl/cgp_decode.sv
module cgp_decode
    import cgp_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    always_comb begin
        unique case (int'(addr))
            OFS_MODE:    sel = SEL_MODE;
            OFS_DIV:     sel = SEL_DIV;
            OFS_STAT:    sel = SEL_STAT;
            OFS_PWR:     sel = SEL_PWR;
            OFS_CLK:     sel = SEL_CLK;
            OFS_IRQ_REQ: sel = SEL_IRQ_REQ;
            OFS_IRQ_MSK: sel = SEL_IRQ_MSK;
            OFS_IRQ_STS: sel = SEL_IRQ_STS;
            OFS_DIR:     sel = SEL_DIR;
            OFS_LVL_W:   sel = SEL_LVL_W;
            OFS_LVL_R:   sel = SEL_LVL_R;
            default:     sel = SEL_NONE;
        endcase
    end

endmodule

// File: rtl/cgp_ctlregs.sv
module cgp_ctlregs
    import cgp_pkg::*;
#(
    parameter int          REG_W      = 16,
    parameter logic [15:0] STATUS_RST = 16'h0002,
    parameter int          PWR_TRIG   = 7,
    parameter logic [15:0] PWR_FORCE  = 16'h8040
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  reg_sel_e         sel,
    input  logic [REG_W-1:0] wval,
    output logic [REG_W-1:0] rval
);

    localparam logic [REG_W-1:0] STAT_VAL  = REG_W'(STATUS_RST);
    localparam logic [REG_W-1:0] FORCE_VAL = REG_W'(PWR_FORCE);

    logic [REG_W-1:0] mode_q, div_q, pwr_q, clk_q;
    logic [REG_W-1:0] irq_req_q, irq_msk_q, irq_sts_q;
    logic [REG_W-1:0] pwr_next;

    // Power side effect: trigger bit forces extra bits on
    assign pwr_next = wval[PWR_TRIG] ? (wval | FORCE_VAL) : wval;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= '0;
            div_q     <= '0;
            pwr_q     <= '0;
            clk_q     <= '0;
            irq_req_q <= '0;
            irq_msk_q <= '0;
            irq_sts_q <= '0;
        end else if (wr_en) begin
            unique case (sel)
                SEL_MODE:    mode_q    <= wval;
                SEL_DIV:     div_q     <= wval;
                SEL_PWR:     pwr_q     <= pwr_next;
                SEL_CLK:     clk_q     <= wval;
                SEL_IRQ_REQ: irq_req_q <= wval;
                SEL_IRQ_MSK: irq_msk_q <= wval;
                SEL_IRQ_STS: irq_sts_q <= wval;
                default:     ;
            endcase
        end
    end

    always_comb begin
        unique case (sel)
            SEL_MODE:    rval = mode_q;
            SEL_DIV:     rval = div_q;
            SEL_STAT:    rval = STAT_VAL;
            SEL_PWR:     rval = pwr_q;
            SEL_CLK:     rval = clk_q;
            SEL_IRQ_REQ: rval = irq_req_q;
            SEL_IRQ_MSK: rval = irq_msk_q;
            SEL_IRQ_STS: rval = irq_sts_q;
            default:     rval = '0;
        endcase
    end

endmodule

// File: rtl/cgp_gpio.sv
module cgp_gpio
    import cgp_pkg::*;
#(
    parameter int LINES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  reg_sel_e         sel,
    input  logic [LINES-1:0] wval,
    input  logic [LINES-1:0] pins_in,
    output logic [LINES-1:0] pins_out,
    output logic [LINES-1:0] pins_chg,
    output logic [LINES-1:0] rval
);

    logic [LINES-1:0] dir_q, lvl_q, drive_q, samp_q, chg_q;
    logic [LINES-1:0] dir_next, lvl_next, drive_next, blend;
    logic             wr_dir, wr_lvl;

    assign wr_dir     = wr_en && (sel == SEL_DIR);
    assign wr_lvl     = wr_en && (sel == SEL_LVL_W || sel == SEL_LVL_R);
    assign dir_next   = wr_dir ? wval : dir_q;
    assign lvl_next   = wr_lvl ? (wval & dir_q) : lvl_q;
    assign drive_next = lvl_next & dir_next;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q   <= '0;
            lvl_q   <= '0;
            drive_q <= '0;
            chg_q   <= '0;
            samp_q  <= '0;
        end else begin
            dir_q   <= dir_next;
            lvl_q   <= lvl_next;
            drive_q <= drive_next;
            chg_q   <= (wr_dir || wr_lvl) ? (drive_q ^ drive_next) : '0;
            samp_q  <= pins_in;
        end
    end

    for (genvar i = 0; i < LINES; i++) begin : g_blend
        assign blend[i] = dir_q[i] ? lvl_q[i] : samp_q[i];
    end

    always_comb begin
        unique case (sel)
            SEL_DIR:   rval = dir_q;
            SEL_LVL_W: rval = lvl_q;
            SEL_LVL_R: rval = blend;
            default:   rval = '0;
        endcase
    end

    assign pins_out = drive_q;
    assign pins_chg = chg_q;

endmodule

// File: rtl/cgp_top.sv
module cgp_top
    import cgp_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int REG_W  = 16,
    parameter int LINES  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err,
    input  logic [LINES-1:0]  gpio_in,
    output logic [LINES-1:0]  gpio_out,
    output logic [LINES-1:0]  gpio_chg
);

    reg_sel_e         sel;
    logic [REG_W-1:0] wval, ctl_rval;
    logic [LINES-1:0] gpio_rval;
    logic [REG_W-1:0] rd_mux;
    logic             is_gpio;
    logic             unused_hi;

    assign wval      = bus_wdata[REG_W-1:0];
    assign unused_hi = ^bus_wdata[DATA_W-1:REG_W];
    assign is_gpio   = (sel == SEL_DIR) || (sel == SEL_LVL_W) || (sel == SEL_LVL_R);
    assign rd_mux    = is_gpio ? REG_W'(gpio_rval) : ctl_rval;

    cgp_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    cgp_ctlregs #(.REG_W(REG_W)) u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (bus_wr),
        .sel   (sel),
        .wval  (wval),
        .rval  (ctl_rval)
    );

    cgp_gpio #(.LINES(LINES)) u_gpio (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr),
        .sel      (sel),
        .wval     (wval[LINES-1:0]),
        .pins_in  (gpio_in),
        .pins_out (gpio_out),
        .pins_chg (gpio_chg),
        .rval     (gpio_rval)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            bus_err   <= 1'b0;
        end else begin
            if (bus_rd) bus_rdata <= DATA_W'(rd_mux);
            bus_err <= (bus_rd || bus_wr) && (sel == SEL_NONE);
        end
    end

endmodule

// File: rtl/cgp_chk.sv
module cgp_chk #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int LINES  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              bus_err,
    input logic [LINES-1:0]  gpio_out,
    input logic [LINES-1:0]  gpio_chg
);

    AST_CHG_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (gpio_chg != '0) |-> $past(bus_wr)); // R9

    AST_CHG_TRACKS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (gpio_out != $past(gpio_out)) |-> (gpio_chg == (gpio_out ^ $past(gpio_out)))); // R9

    AST_ERR_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(bus_rd || bus_wr)); // R10

    AST_STATUS_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bus_rd) && $past(bus_addr) == ADDR_W'(8)) |-> (bus_rdata == DATA_W'(2))); // R3

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(bus_rd) && $past(rst_n)) |-> $stable(bus_rdata)); // R11

endmodule

bind cgp_top cgp_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_rdata (bus_rdata),
    .bus_err   (bus_err),
    .gpio_out  (gpio_out),
    .gpio_chg  (gpio_chg)
);

// File: tb/sim_cgp_top.sv
module sim_cgp_top;

    typedef struct packed {
        logic        wr;     // 1 = write, 0 = read
        logic [11:0] addr;
        logic [31:0] data;
        logic [15:0] exp_a;  // read: rdata, write: gpio_chg
        logic [15:0] exp_b;  // write: gpio_out
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 12'h000, 32'hABCD1234, 16'h0000, 16'h0000, 4'd1},  // R1
        '{1'b0, 12'h000, 32'h0,        16'h1234, 16'h0000, 4'd1},  // R1 truncation
        '{1'b1, 12'h004, 32'h00005555, 16'h0000, 16'h0000, 4'd1},
        '{1'b0, 12'h004, 32'h0,        16'h5555, 16'h0000, 4'd1},
        '{1'b1, 12'h010, 32'h000000FF, 16'h0000, 16'h0000, 4'd1},
        '{1'b0, 12'h010, 32'h0,        16'h00FF, 16'h0000, 4'd1},
        '{1'b1, 12'h014, 32'h00011111, 16'h0000, 16'h0000, 4'd1},
        '{1'b1, 12'h018, 32'h00002222, 16'h0000, 16'h0000, 4'd1},
        '{1'b1, 12'h01C, 32'hFFFF3333, 16'h0000, 16'h0000, 4'd1},
        '{1'b0, 12'h014, 32'h0,        16'h1111, 16'h0000, 4'd1},
        '{1'b0, 12'h018, 32'h0,        16'h2222, 16'h0000, 4'd1},
        '{1'b0, 12'h01C, 32'h0,        16'h3333, 16'h0000, 4'd1},
        '{1'b1, 12'h00C, 32'h00000081, 16'h0000, 16'h0000, 4'd4},  // R4
        '{1'b0, 12'h00C, 32'h0,        16'h80C1, 16'h0000, 4'd4},
        '{1'b1, 12'h00C, 32'h00000005, 16'h0000, 16'h0000, 4'd4},
        '{1'b0, 12'h00C, 32'h0,        16'h0005, 16'h0000, 4'd4},
        '{1'b1, 12'h008, 32'h0000FFFF, 16'h0000, 16'h0000, 4'd3},  // R3
        '{1'b0, 12'h008, 32'h0,        16'h0002, 16'h0000, 4'd3},
        '{1'b1, 12'h020, 32'h000000FF, 16'h0000, 16'h0000, 4'd9},  // R9 no toggle
        '{1'b1, 12'h024, 32'h0000F0F3, 16'h00F3, 16'h00F3, 4'd5},  // R5 R8
        '{1'b0, 12'h024, 32'h0,        16'h00F3, 16'h0000, 4'd6},  // R6
        '{1'b0, 12'h020, 32'h0,        16'h00FF, 16'h0000, 4'd6},
        '{1'b1, 12'h028, 32'h00000F0F, 16'h00FC, 16'h000F, 4'd5},  // R5 via read offset
        '{1'b1, 12'h020, 32'h00000003, 16'h000C, 16'h0003, 4'd8},  // R8 dir narrows
        '{1'b1, 12'h020, 32'h0000000F, 16'h000C, 16'h000F, 4'd8},  // level kept
        '{1'b1, 12'h024, 32'h0000000F, 16'h0000, 16'h000F, 4'd9},  // R9 zero strobe
        '{1'b0, 12'h024, 32'h0,        16'h000F, 16'h0000, 4'd6}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic [15:0] gpio_in = '0;
    logic [15:0] gpio_out;
    logic [15:0] gpio_chg;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    cgp_top u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_err   (bus_err),
        .gpio_in   (gpio_in),
        .gpio_out  (gpio_out),
        .gpio_chg  (gpio_chg)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one access at a falling edge; return at the next falling edge
    task automatic access(input logic wr, input logic rd, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2 reset state
        check("R2 gpio_out", 32'(gpio_out), 32'h0);
        check("R2 gpio_chg", 32'(gpio_chg), 32'h0);
        check("R2 bus_err", 32'(bus_err), 32'h0);
        access(1'b0, 1'b1, 12'h008, 32'h0);
        check("R2 status", bus_rdata, 32'h0002);
        access(1'b0, 1'b1, 12'h00C, 32'h0);
        check("R2 power", bus_rdata, 32'h0000);
        access(1'b0, 1'b1, 12'h020, 32'h0);
        check("R2 direction", bus_rdata, 32'h0000);

        for (int i = 0; i < NV; i++) begin
            access(VEC[i].wr, !VEC[i].wr, VEC[i].addr, VEC[i].data);
            if (VEC[i].wr) begin
                checks++;
                if (gpio_chg !== VEC[i].exp_a || gpio_out !== VEC[i].exp_b) begin
                    fails++;
                    $display("FAIL R%0d vec %0d: actual chg=%h out=%h expected chg=%h out=%h",
                             VEC[i].req, i, gpio_chg, gpio_out, VEC[i].exp_a, VEC[i].exp_b);
                end
            end else begin
                checks++;
                if (bus_rdata !== {16'h0, VEC[i].exp_a}) begin
                    fails++;
                    $display("FAIL R%0d vec %0d: actual %h expected %h",
                             VEC[i].req, i, bus_rdata, {16'h0, VEC[i].exp_a});
                end
            end
        end

        // R9 strobe lasts one clock: dir 0x000F -> 0x0000 toggles four lines
        access(1'b1, 1'b0, 12'h020, 32'h0);
        check("R9 strobe", 32'(gpio_chg), 32'h000F);
        @(negedge clk);
        check("R9 strobe drops", 32'(gpio_chg), 32'h0);
        access(1'b1, 1'b0, 12'h020, 32'h000F);

        // R7 blended read of the read-side offset
        gpio_in = 16'hA5A5;
        repeat (2) @(negedge clk);
        access(1'b0, 1'b1, 12'h028, 32'h0);
        check("R7 blend", bus_rdata, 32'h0000A5AF);
        access(1'b0, 1'b1, 12'h024, 32'h0);
        check("R7 level untouched", bus_rdata, 32'h0000000F);

        // R11 rdata holds with no read
        @(negedge clk);
        check("R11 hold", bus_rdata, 32'h0000000F);

        // R10 undecoded write, read and misaligned access
        access(1'b1, 1'b0, 12'hFFC, 32'h0000BEEF);
        check("R10 err write", 32'(bus_err), 32'h1);
        @(negedge clk);
        check("R10 err one clock", 32'(bus_err), 32'h0);
        access(1'b0, 1'b1, 12'h002, 32'h0);
        check("R10 misaligned rdata", bus_rdata, 32'h0);
        check("R10 err read", 32'(bus_err), 32'h1);
        access(1'b1, 1'b0, 12'h001, 32'h0000FFFF);
        access(1'b0, 1'b1, 12'h000, 32'h0);
        check("R10 mode unchanged", bus_rdata, 32'h00001234);
        check("R10 no err decoded", 32'(bus_err), 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule